// File: doc/BRIEF.md
# Polar Decoder LLR Node Unit

This block is the arithmetic heart of one stage of a successive-cancellation polar decoder. Each cycle it may accept two log-likelihood ratios (LLRs), an upper value `a` and a lower value `b`, together with a partial-sum bit and a node selector. It returns either the check-node (f) update or the bit-node (g) update to the next stage. LLRs travel in sign-magnitude form. The most significant bit is the sign (1 means negative) and the remaining bits hold the magnitude.

The f update uses the min-sum rule and works directly on the sign-magnitude fields. The g update converts both inputs to two's complement and forms both `b + a` and `b - a`. The partial-sum bit picks one of the two results, which is then clipped and converted back to sign-magnitude. The result is registered, so it appears one cycle after the valid strobe.

Top module: `sc_llr_node_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld` becomes 0 and `llr_out` becomes all zeros.
- R2: `out_vld` equals the `in_vld` value of the previous cycle, so each result appears exactly one cycle after its input.
- R3: With `node_sel` = 0 (f node), the output magnitude is the smaller of the two input magnitudes. The output sign is the XOR of the two input sign bits, where bit LLR_W-1 is the sign (1 = negative) and bits LLR_W-2..0 are the magnitude.
- R4: With `node_sel` = 1 (g node), the output value is `b + a` when `psum` = 0 and `b - a` when `psum` = 1.
- R5: A g result whose magnitude exceeds 2^(LLR_W-1)-1 is clipped to that largest magnitude, keeping its sign, instead of wrapping.
- R6: An input holding negative zero (sign 1, magnitude 0) behaves exactly like positive zero in both node types.
- R7: `llr_out` never holds negative zero while `out_vld` is 1. A zero result is always emitted with sign 0.
- R8: In a cycle with `in_vld` = 0, `llr_out` keeps its previous value and the data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input operands are valid this cycle |
| node_sel | input | 1 | 0 = f (min-sum) update, 1 = g update |
| psum | input | 1 | Partial-sum bit: 0 gives b+a, 1 gives b-a |
| llr_a | input | LLR_W | Upper LLR, sign-magnitude |
| llr_b | input | LLR_W | Lower LLR, sign-magnitude |
| out_vld | output | 1 | Result valid |
| llr_out | output | LLR_W | Result LLR, sign-magnitude |

## Verification
The bench targets the following corner cases:
- **Saturation.** It drives both g sums to their extremes (±31 plus ±31). A wrapping adder would return a small value with the wrong sign.
- **Sign handling at zero.** It feeds negative zero to both node types and makes results cancel to zero. A design that converts naively would emit negative zero or flip the f sign.
- **Partial-sum selection.** It covers equal magnitudes with opposite signs and swapped operand order. These catch a swapped subtractor or an inverted partial-sum select.
- **Idle cycles.** It changes the data while the valid strobe is low. A design that loads regardless of the strobe would corrupt the held output.

// File: rtl/sc_pe_pkg.sv
package sc_pe_pkg;
  typedef enum logic {
    NODE_F = 1'b0,
    NODE_G = 1'b1
  } node_e;
endpackage

// File: rtl/sc_sm2tc.sv
// Sign-magnitude to two's complement; negative zero maps to zero.
module sc_sm2tc #(
  parameter int LLR_W = 6
) (
  input  logic [LLR_W-1:0]        sm,
  output logic signed [LLR_W-1:0] tc
);
  localparam int MAG_W = LLR_W - 1;
  logic signed [LLR_W-1:0] mag_s;
  always_comb begin
    mag_s = $signed({1'b0, sm[MAG_W-1:0]});
    tc    = sm[LLR_W-1] ? -mag_s : mag_s;
  end
endmodule

// File: rtl/sc_tc2sm_sat.sv
// Two's complement to sign-magnitude with clipping to the largest magnitude.
module sc_tc2sm_sat #(
  parameter int W_IN  = 7,
  parameter int LLR_W = 6
) (
  input  logic signed [W_IN-1:0] tc,
  output logic [LLR_W-1:0]       sm
);
  localparam int MAG_W = LLR_W - 1;
  localparam logic [W_IN-1:0] SAT = W_IN'((1 << MAG_W) - 1);
  logic            neg;
  logic [W_IN-1:0] absval;
  logic [MAG_W-1:0] mag;
  always_comb begin
    neg    = tc[W_IN-1];
    absval = neg ? W_IN'(-tc) : W_IN'(tc);
    mag    = (absval > SAT) ? SAT[MAG_W-1:0] : absval[MAG_W-1:0];
    sm     = {neg, mag};
  end
endmodule

// File: rtl/sc_fnode_min.sv
// Min-sum f update computed directly in sign-magnitude.
module sc_fnode_min #(
  parameter int LLR_W = 6
) (
  input  logic [LLR_W-1:0] a,
  input  logic [LLR_W-1:0] b,
  output logic [LLR_W-1:0] f
);
  localparam int MAG_W = LLR_W - 1;
  logic [MAG_W-1:0] mag;
  always_comb begin
    mag = (a[MAG_W-1:0] < b[MAG_W-1:0]) ? a[MAG_W-1:0] : b[MAG_W-1:0];
    f   = {(mag != '0) & (a[LLR_W-1] ^ b[LLR_W-1]), mag};
  end
endmodule

// File: rtl/sc_llr_node_unit.sv
module sc_llr_node_unit
  import sc_pe_pkg::*;
#(
  parameter int LLR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             node_sel,
  input  logic             psum,
  input  logic [LLR_W-1:0] llr_a,
  input  logic [LLR_W-1:0] llr_b,
  output logic             out_vld,
  output logic [LLR_W-1:0] llr_out
);
  localparam int SUM_W = LLR_W + 1;

  logic signed [LLR_W-1:0] ta, tb;
  logic signed [SUM_W-1:0] g_add, g_sub, g_sel;
  logic [LLR_W-1:0]        f_sm, g_sm;

  sc_sm2tc #(.LLR_W(LLR_W)) u_cva (.sm(llr_a), .tc(ta));
  sc_sm2tc #(.LLR_W(LLR_W)) u_cvb (.sm(llr_b), .tc(tb));

  always_comb begin
    g_add = SUM_W'(tb) + SUM_W'(ta);
    g_sub = SUM_W'(tb) - SUM_W'(ta);
    g_sel = psum ? g_sub : g_add;
  end

  sc_tc2sm_sat #(.W_IN(SUM_W), .LLR_W(LLR_W)) u_cvo (.tc(g_sel), .sm(g_sm));
  sc_fnode_min #(.LLR_W(LLR_W)) u_fmin (.a(llr_a), .b(llr_b), .f(f_sm));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      llr_out <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) llr_out <= (node_e'(node_sel) == NODE_G) ? g_sm : f_sm;
    end
  end
endmodule

// File: rtl/sc_llr_node_chk.sv
module sc_llr_node_chk #(
  parameter int LLR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             node_sel,
  input logic             psum,
  input logic [LLR_W-1:0] llr_a,
  input logic [LLR_W-1:0] llr_b,
  input logic             out_vld,
  input logic [LLR_W-1:0] llr_out
);
  localparam int MAG_W = LLR_W - 1;
  localparam logic [LLR_W-1:0] NEG_ZERO = {1'b1, {MAG_W{1'b0}}};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  a_r7_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (llr_out != NEG_ZERO));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(llr_out));
  a_r3_f_min_a: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !node_sel) |=> (llr_out[MAG_W-1:0] <= $past(llr_a[MAG_W-1:0])));
  a_r3_f_min_b: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !node_sel) |=> (llr_out[MAG_W-1:0] <= $past(llr_b[MAG_W-1:0])));
  a_r4_g_zero_a: assert property (@(posedge clk) disable iff (rst)
    (in_vld && node_sel && llr_a[MAG_W-1:0] == '0 && llr_b[MAG_W-1:0] != '0)
      |=> (llr_out == $past(llr_b)));
endmodule

bind sc_llr_node_unit sc_llr_node_chk #(.LLR_W(LLR_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .node_sel(node_sel), .psum(psum),
  .llr_a(llr_a), .llr_b(llr_b), .out_vld(out_vld), .llr_out(llr_out)
);

// File: tb/sim_sc_llr_node_unit.sv
module sim_sc_llr_node_unit;
  localparam int W = 6;
  localparam int MAXM = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0, node_sel = 1'b0, psum = 1'b0;
  logic [W-1:0] llr_a = '0, llr_b = '0;
  logic out_vld;
  logic [W-1:0] llr_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_llr_node_unit #(.LLR_W(W)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .node_sel(node_sel), .psum(psum),
    .llr_a(llr_a), .llr_b(llr_b), .out_vld(out_vld), .llr_out(llr_out)
  );

  function automatic int sm_val(input logic [W-1:0] x);
    int m = int'(x[W-2:0]);
    return x[W-1] ? -m : m;
  endfunction

  function automatic logic [W-1:0] enc(input int v);
    int m = (v < 0) ? -v : v;
    if (m > MAXM) m = MAXM;
    return {(v < 0), (W-1)'(m)};
  endfunction

  function automatic logic [W-1:0] ref_pe(input logic sel, input logic ps,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    int ma = int'(a[W-2:0]);
    int mb = int'(b[W-2:0]);
    int m  = (ma < mb) ? ma : mb;
    if (!sel) return {(m != 0) && (a[W-1] != b[W-1]), (W-1)'(m)};
    return ps ? enc(sm_val(b) - sm_val(a)) : enc(sm_val(b) + sm_val(a));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic sel, input logic ps,
                    input logic [W-1:0] a, input logic [W-1:0] b);
    in_vld = 1'b1; node_sel = sel; psum = ps; llr_a = a; llr_b = b;
    @(negedge clk);
    in_vld = 1'b0;
    chk({req, " valid"}, W'(out_vld), W'(1));
    chk(req, llr_out, ref_pe(sel, ps, a, b));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 reset valid", W'(out_vld), W'(0));
    chk("R1 reset data", llr_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 idle valid", W'(out_vld), W'(0));
    // R3 f node: sign XOR, min magnitude
    op("R3 f opp sign", 1'b0, 1'b0, 6'b1_00101, 6'b0_01100);
    op("R3 f both neg", 1'b0, 1'b0, 6'b1_11111, 6'b1_00011);
    op("R3 f max", 1'b0, 1'b0, 6'b0_11111, 6'b1_11111);
    // R4 g node
    op("R4 g add", 1'b1, 1'b0, 6'b0_00111, 6'b1_00010);
    op("R4 g sub", 1'b1, 1'b1, 6'b0_00111, 6'b1_00010);
    op("R4 g sub swap", 1'b1, 1'b1, 6'b1_00010, 6'b0_00111);
    // R5 saturation
    op("R5 sat pos", 1'b1, 1'b0, 6'b0_11111, 6'b0_11111);
    op("R5 sat neg", 1'b1, 1'b0, 6'b1_11111, 6'b1_11111);
    op("R5 sat sub", 1'b1, 1'b1, 6'b1_10000, 6'b0_10001);
    // R6 negative zero input
    op("R6 f negzero", 1'b0, 1'b0, 6'b1_00000, 6'b0_00110);
    op("R6 g negzero", 1'b1, 1'b1, 6'b1_00000, 6'b1_01001);
    // R7 zero result never negative
    op("R7 g cancel", 1'b1, 1'b0, 6'b1_01010, 6'b0_01010);
    op("R7 g sub zero", 1'b1, 1'b1, 6'b1_00100, 6'b1_00100);
    op("R7 both negzero", 1'b1, 1'b0, 6'b1_00000, 6'b1_00000);
    // R8 hold while idle
    op("R8 setup", 1'b1, 1'b0, 6'b0_00011, 6'b0_00100);
    node_sel = 1'b0; llr_a = 6'b1_00001; llr_b = 6'b0_00001;
    @(negedge clk);
    chk("R8 hold valid", W'(out_vld), W'(0));
    chk("R8 hold data", llr_out, 6'b0_00111);
    // random mix (R3 R4 R5)
    for (int i = 0; i < 400; i++) begin
      op("R3/R4 random", 1'($urandom), 1'($urandom), W'($urandom), W'($urandom));
      if (($urandom % 4) == 0) @(negedge clk);
    end
    // back-to-back R2
    in_vld = 1'b1; node_sel = 1'b1; psum = 1'b0; llr_a = 6'b0_00001; llr_b = 6'b0_00001;
    @(negedge clk);
    llr_a = 6'b0_00010;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R2 b2b valid", W'(out_vld), W'(1));
    chk("R2 b2b data", llr_out, 6'b0_00011);
    @(negedge clk);
    chk("R2 drop valid", W'(out_vld), W'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule